// File: doc/BRIEF.md
# Load Alias Prediction Table

This block decides, for each load that reaches dispatch, whether the load may go to memory ahead of older stores whose addresses are still unknown. It keeps a small table with one entry per slice of the load instruction address. Each entry holds a partial tag and a saturating confidence counter. A load whose entry is at full confidence, or whose entry belongs to another load, is let through. A load whose entry has lost confidence is held until every older store address has resolved.

A collision check runs each cycle. It compares a store address that has just resolved against a younger load that has already issued. A match raises a squash request that carries the load's instruction address. The same event drives that load's entry to zero confidence and writes the load's tag into it. Each speculative issue that finishes cleanly raises the confidence by one step. A clear input returns every entry to full confidence, so that an entry marked unsafe long ago does not hold its load back for ever. The load/store queue, the cache and the replay machinery lie outside the block and reach it only as plain signals.

Top module: `load_alias_predictor`

## Requirements
- R1: After reset every entry reads as safe: count 3, tag 0. With no request valid, `lk_issue_o`, `lk_hold_o` and `squash_o` are 0 and `squash_pc_o` is 0.
- R2: The entry index is PC bits [7:2] (64 entries). The entry tag is PC bits [11:8]. PC bits [1:0] and bits 12 and up play no part.
- R3: A collision exists in a cycle when `st_res_valid_i` and `yld_valid_i` are both 1 and the two addresses agree in bits [31:3] (an 8-byte granule). In that cycle `squash_o` is 1 and `squash_pc_o` equals `yld_pc_i`. In any other cycle both are 0.
- R4: A collision sets the entry indexed by `yld_pc_i` to count 0 and writes the tag of `yld_pc_i` into it. A later lookup of that PC then reads unsafe.
- R5: A valid `done_pc_i` whose tag equals the stored tag raises that entry's count by one, saturating at 3. A lookup whose tag matches reads safe only at count 3.
- R6: A lookup whose tag differs from the stored tag reads safe. A completion whose tag differs from the stored tag leaves the entry unchanged.
- R7: `lk_issue_o` = `lk_valid_i` AND (safe OR NOT `lk_older_unres_i`). `lk_hold_o` = `lk_valid_i` AND `lk_older_unres_i` AND NOT safe.
- R8: A lookup in the same cycle as a collision or a completion on the same entry reads the entry as it will be after that update.
- R9: `clear_i` sets every count to 3 at the next edge. A collision in the same cycle still leaves its own entry at count 0.
- R10: If a collision and a completion hit the same entry in the same cycle, the collision wins and the count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Return all entries to full confidence |
| lk_valid_i | input | 1 | A load asks whether it may issue |
| lk_pc_i | input | 32 | Instruction address of that load |
| lk_older_unres_i | input | 1 | Some older store has an unknown address |
| lk_safe_o | output | 1 | Prediction for `lk_pc_i`: 1 means no alias expected |
| lk_issue_o | output | 1 | The load may issue now |
| lk_hold_o | output | 1 | The load must wait for older store addresses |
| st_res_valid_i | input | 1 | A store address resolved this cycle |
| st_res_addr_i | input | 32 | The resolved store address |
| yld_valid_i | input | 1 | A younger, already-issued load is offered for comparison |
| yld_addr_i | input | 32 | Data address of that younger load |
| yld_pc_i | input | 32 | Instruction address of that younger load |
| done_valid_i | input | 1 | A speculatively issued load finished without collision |
| done_pc_i | input | 32 | Instruction address of the finished load |
| squash_o | output | 1 | Collision found: squash and replay |
| squash_pc_o | output | 32 | Instruction address of the load to replay |

## Verification
The assertions take for granted that the queue only offers a younger load for comparison together with a store resolution, and that reset is held for at least one edge before any request. They also assume a completion is never reported for a load that was squashed in the same cycle. The stimulus never pairs a completion with a collision on the same load except in the one directed case that checks R10. Apart from that case it drives each update only where its effect follows from a single rule. Every input is driven after the falling edge, so the assertions see settled values at the rising edge.

// File: rtl/lapt_pkg.sv
package lapt_pkg;

  // Extract w bits of v starting at lsb.
  function automatic logic [63:0] bit_field(input logic [63:0] v,
                                            input int unsigned lsb,
                                            input int unsigned w);
    return (v >> lsb) & ((64'd1 << w) - 64'd1);
  endfunction

  // Saturating increment toward top.
  function automatic logic [31:0] sat_up(input logic [31:0] c,
                                         input logic [31:0] top);
    return (c >= top) ? top : c + 32'd1;
  endfunction

  // Two addresses fall in the same aligned granule of 2**lsb bytes.
  function automatic logic same_granule(input logic [63:0] a,
                                        input logic [63:0] b,
                                        input int unsigned lsb);
    return (a >> lsb) == (b >> lsb);
  endfunction

endpackage

// File: rtl/lapt_index.sv
module lapt_index #(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 4
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  import lapt_pkg::*;

  localparam int TAG_LSB = PC_LSB + IDX_W;

  assign idx = IDX_W'(bit_field(64'(pc), PC_LSB, IDX_W));
  assign tag = TAG_W'(bit_field(64'(pc), TAG_LSB, TAG_W));
endmodule

// File: rtl/lapt_conflict.sv
module lapt_conflict #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3
) (
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              hit
);
  import lapt_pkg::*;

  assign hit = st_valid && ld_valid &&
               same_granule(64'(st_addr), 64'(ld_addr), GRAN_LSB);
endmodule

// File: rtl/lapt_entry.sv
module lapt_entry #(
  parameter int TAG_W = 4,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             viol_hit,
  input  logic [TAG_W-1:0] viol_tag,
  input  logic             done_hit,
  input  logic [TAG_W-1:0] done_tag,
  output logic [CNT_W-1:0] cnt_q,
  output logic [TAG_W-1:0] tag_q,
  output logic [CNT_W-1:0] cnt_n,
  output logic [TAG_W-1:0] tag_n
);
  import lapt_pkg::*;

  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [31:0]      CNT_TOP32 = 32'(CNT_TOP);

  // Priority, lowest first: completion, clear, collision.
  always_comb begin
    cnt_n = cnt_q;
    tag_n = tag_q;
    if (done_hit && (done_tag == tag_q)) begin
      cnt_n = CNT_W'(sat_up(32'(cnt_q), CNT_TOP32));
    end
    if (clear) begin
      cnt_n = CNT_TOP;
    end
    if (viol_hit) begin
      cnt_n = '0;
      tag_n = viol_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= CNT_TOP;
      tag_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      tag_q <= tag_n;
    end
  end
endmodule

// File: rtl/lapt_gate.sv
module lapt_gate (
  input  logic valid,
  input  logic unres,
  input  logic safe,
  output logic issue,
  output logic hold
);
  assign issue = valid && (safe || !unres);
  assign hold  = valid && unres && !safe;
endmodule

// File: rtl/load_alias_predictor.sv
module load_alias_predictor #(
  parameter int PC_W     = 32,
  parameter int ADDR_W   = 32,
  parameter int PC_LSB   = 2,
  parameter int IDX_W    = 6,
  parameter int TAG_W    = 4,
  parameter int CNT_W    = 2,
  parameter int GRAN_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              lk_valid_i,
  input  logic [PC_W-1:0]   lk_pc_i,
  input  logic              lk_older_unres_i,
  output logic              lk_safe_o,
  output logic              lk_issue_o,
  output logic              lk_hold_o,
  input  logic              st_res_valid_i,
  input  logic [ADDR_W-1:0] st_res_addr_i,
  input  logic              yld_valid_i,
  input  logic [ADDR_W-1:0] yld_addr_i,
  input  logic [PC_W-1:0]   yld_pc_i,
  input  logic              done_valid_i,
  input  logic [PC_W-1:0]   done_pc_i,
  output logic              squash_o,
  output logic [PC_W-1:0]   squash_pc_o
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  // Named internal events, visible to the checker.
  logic                     viol;
  logic [IDX_W-1:0]         viol_idx;
  logic [TAG_W-1:0]         viol_tag;
  logic [IDX_W-1:0]         done_idx;
  logic [TAG_W-1:0]         done_tag;
  logic [IDX_W-1:0]         lk_idx;
  logic [TAG_W-1:0]         lk_tag;
  logic [CNT_W-1:0]         sel_cnt;
  logic [TAG_W-1:0]         sel_tag;
  logic                     lk_safe;
  logic [ENTRIES*CNT_W-1:0] cnt_q_flat;

  logic [CNT_W-1:0] cnt_q [ENTRIES];
  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [CNT_W-1:0] cnt_n [ENTRIES];
  logic [TAG_W-1:0] tag_n [ENTRIES];

  lapt_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W))
    u_ix_lk   (.pc(lk_pc_i),   .idx(lk_idx),   .tag(lk_tag));
  lapt_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W))
    u_ix_yld  (.pc(yld_pc_i),  .idx(viol_idx), .tag(viol_tag));
  lapt_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W))
    u_ix_done (.pc(done_pc_i), .idx(done_idx), .tag(done_tag));

  lapt_conflict #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_conflict (
    .st_valid (st_res_valid_i),
    .st_addr  (st_res_addr_i),
    .ld_valid (yld_valid_i),
    .ld_addr  (yld_addr_i),
    .hit      (viol)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic v_hit;
    logic d_hit;
    assign v_hit = viol && (viol_idx == IDX_W'(g));
    assign d_hit = done_valid_i && (done_idx == IDX_W'(g));

    lapt_entry #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear_i),
      .viol_hit (v_hit),
      .viol_tag (viol_tag),
      .done_hit (d_hit),
      .done_tag (done_tag),
      .cnt_q    (cnt_q[g]),
      .tag_q    (tag_q[g]),
      .cnt_n    (cnt_n[g]),
      .tag_n    (tag_n[g])
    );

    assign cnt_q_flat[g*CNT_W +: CNT_W] = cnt_q[g];
  end

  // Lookup reads the next-state view so same-cycle training is reflected.
  assign sel_cnt = cnt_n[lk_idx];
  assign sel_tag = tag_n[lk_idx];
  assign lk_safe = (sel_tag != lk_tag) || (sel_cnt == CNT_TOP);

  lapt_gate u_gate (
    .valid (lk_valid_i),
    .unres (lk_older_unres_i),
    .safe  (lk_safe),
    .issue (lk_issue_o),
    .hold  (lk_hold_o)
  );

  assign lk_safe_o   = lk_safe;
  assign squash_o    = viol;
  assign squash_pc_o = viol ? yld_pc_i : '0;
endmodule

// File: rtl/load_alias_predictor_chk.sv
module load_alias_predictor_chk #(
  parameter int IDX_W = 6,
  parameter int CNT_W = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          clear_i,
  input logic                          lk_valid_i,
  input logic                          lk_older_unres_i,
  input logic                          lk_issue_o,
  input logic                          lk_hold_o,
  input logic                          st_res_valid_i,
  input logic                          yld_valid_i,
  input logic                          squash_o,
  input logic [IDX_W-1:0]              viol_idx,
  input logic [(1<<IDX_W)*CNT_W-1:0]   cnt_q_flat
);
  logic             v_q;
  logic [IDX_W-1:0] v_idx_q;
  logic             c_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      v_idx_q <= '0;
      c_q     <= 1'b0;
    end else begin
      v_q     <= squash_o;
      v_idx_q <= viol_idx;
      c_q     <= clear_i;
    end
  end

  a_r3_squash_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |-> (st_res_valid_i && yld_valid_i));

  a_r4_collision_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |-> (cnt_q_flat[v_idx_q*CNT_W +: CNT_W] == '0));

  a_r7_issue_hold_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_issue_o && lk_hold_o));

  a_r7_free_path_issues: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_i && !lk_older_unres_i) |-> lk_issue_o);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid_i |-> (!lk_issue_o && !lk_hold_o));

  a_r9_clear_arms_all: assert property (@(posedge clk) disable iff (!rst_n)
    (c_q && !v_q) |-> (&cnt_q_flat));
endmodule

bind load_alias_predictor load_alias_predictor_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .clear_i          (clear_i),
  .lk_valid_i       (lk_valid_i),
  .lk_older_unres_i (lk_older_unres_i),
  .lk_issue_o       (lk_issue_o),
  .lk_hold_o        (lk_hold_o),
  .st_res_valid_i   (st_res_valid_i),
  .yld_valid_i      (yld_valid_i),
  .squash_o         (squash_o),
  .viol_idx         (viol_idx),
  .cnt_q_flat       (cnt_q_flat)
);

// File: tb/test_load_alias_predictor.sv
`timescale 1ns/1ps
module test_load_alias_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear_i = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_pc_i = '0;
  logic        lk_older_unres_i = 1'b0;
  logic        lk_safe_o, lk_issue_o, lk_hold_o;
  logic        st_res_valid_i = 1'b0;
  logic [31:0] st_res_addr_i = '0;
  logic        yld_valid_i = 1'b0;
  logic [31:0] yld_addr_i = '0;
  logic [31:0] yld_pc_i = '0;
  logic        done_valid_i = 1'b0;
  logic [31:0] done_pc_i = '0;
  logic        squash_o;
  logic [31:0] squash_pc_o;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  int mc [64];
  int mt [64];

  always #4 clk = ~clk;

  load_alias_predictor i_load_alias_predictor (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
    .lk_valid_i(lk_valid_i), .lk_pc_i(lk_pc_i), .lk_older_unres_i(lk_older_unres_i),
    .lk_safe_o(lk_safe_o), .lk_issue_o(lk_issue_o), .lk_hold_o(lk_hold_o),
    .st_res_valid_i(st_res_valid_i), .st_res_addr_i(st_res_addr_i),
    .yld_valid_i(yld_valid_i), .yld_addr_i(yld_addr_i), .yld_pc_i(yld_pc_i),
    .done_valid_i(done_valid_i), .done_pc_i(done_pc_i),
    .squash_o(squash_o), .squash_pc_o(squash_pc_o)
  );

  function automatic int ix(input logic [31:0] pc);
    return int'((pc / 4) % 64);
  endfunction
  function automatic int tg(input logic [31:0] pc);
    return int'((pc / 256) % 16);
  endfunction
  function automatic logic [31:0] mkpc(input int t, input int i, input int hi);
    return 32'(hi) * 4096 + 32'(t % 16) * 256 + 32'(i % 64) * 4 + 32'(hi % 4);
  endfunction

  // One cycle: drive after falling edge, check before rising edge, advance model.
  task automatic cyc(input bit lv, input logic [31:0] lpc, input bit lun,
                     input bit sv, input logic [31:0] sa,
                     input bit yv, input logic [31:0] ya, input logic [31:0] ypc,
                     input bit dv, input logic [31:0] dpc,
                     input bit clr, input string rq);
    int nc [64];
    int nt [64];
    bit col, esafe;
    logic [35:0] exp_v, act_v;
    @(negedge clk);
    lk_valid_i = lv; lk_pc_i = lpc; lk_older_unres_i = lun;
    st_res_valid_i = sv; st_res_addr_i = sa;
    yld_valid_i = yv; yld_addr_i = ya; yld_pc_i = ypc;
    done_valid_i = dv; done_pc_i = dpc; clear_i = clr;
    #2;
    col = sv && yv && ((sa / 8) == (ya / 8));
    for (int e = 0; e < 64; e++) begin
      nc[e] = mc[e];
      nt[e] = mt[e];
      if (dv && ix(dpc) == e && tg(dpc) == mt[e] && mc[e] < 3) nc[e] = mc[e] + 1;
      if (clr) nc[e] = 3;
      if (col && ix(ypc) == e) begin nc[e] = 0; nt[e] = tg(ypc); end
    end
    esafe = (nt[ix(lpc)] != tg(lpc)) || (nc[ix(lpc)] == 3);
    exp_v = {esafe, lv && (esafe || !lun), lv && lun && !esafe, col, col ? ypc : 32'h0};
    act_v = {lk_safe_o, lk_issue_o, lk_hold_o, squash_o, squash_pc_o};
    vectors++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: {safe,issue,hold,squash,pc} actual=%h expected=%h", rq, act_v, exp_v);
    end
    for (int e = 0; e < 64; e++) begin mc[e] = nc[e]; mt[e] = nt[e]; end
  endtask

  task automatic look(input logic [31:0] pc, input bit un, input string rq);
    cyc(1, pc, un, 0, 0, 0, 0, 0, 0, 0, 0, rq);
  endtask
  task automatic collide(input logic [31:0] pc, input logic [31:0] a, input string rq);
    cyc(0, 0, 0, 1, a, 1, a ^ 32'h5, pc, 0, 0, 0, rq);
  endtask
  task automatic finish_ld(input logic [31:0] pc, input string rq);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, pc, 0, rq);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 64; e++) begin mc[e] = 3; mt[e] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: quiet outputs after reset
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R1 R2: every index reads safe, address bits outside the field ignored
    for (int i = 0; i < 64; i++) look(mkpc(i, i, i * 37 + 1), 1, "R1_R2");

    // R3 R4 R5 R8: per entry, train unsafe then climb back
    for (int i = 0; i < 64; i++) begin
      logic [31:0] p;
      p = mkpc(i % 16, i, 5 + i);
      collide(p, 32'h1000_0000 + 32'(i) * 64, "R3_R4");
      look(p, 1, "R4");
      look(p, 0, "R7");
      look(mkpc((i + 1) % 16, i, 2), 1, "R6");
      finish_ld(p, "R5");
      look(p, 1, "R5");
      finish_ld(p, "R5");
      // completion to full count with lookup in the same cycle
      cyc(1, p, 1, 0, 0, 0, 0, 0, 1, p, 0, "R8_R5");
      look(p, 1, "R5");
    end

    // R3: granule boundary sweep, flipping each address bit
    for (int b = 0; b < 32; b++) begin
      logic [31:0] a;
      a = 32'h2468_ACE0;
      cyc(0, 0, 0, 1, a, 1, a ^ (32'h1 << b), mkpc(3, b, 9), 0, 0, 0, "R3");
    end
    cyc(0, 0, 0, 1, 32'h80, 0, 32'h80, 32'h44, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 32'h80, 1, 32'h80, 32'h44, 0, 0, 0, "R3");

    // R6: completion with foreign tag leaves the entry unsafe
    collide(mkpc(2, 5, 1), 32'h300, "R4");
    for (int k = 0; k < 3; k++) finish_ld(mkpc(3, 5, 1), "R6");
    look(mkpc(2, 5, 1), 1, "R6");

    // R8: collision and lookup of the same load in one cycle
    cyc(1, mkpc(7, 9, 4), 1, 1, 32'h500, 1, 32'h503, mkpc(7, 9, 4), 0, 0, 0, "R8");

    // R10: collision and completion on the same entry together
    for (int k = 0; k < 3; k++) finish_ld(mkpc(7, 9, 4), "R5");
    cyc(1, mkpc(7, 9, 4), 1, 1, 32'h600, 1, 32'h601, mkpc(7, 9, 4), 1, mkpc(7, 9, 4), 0, "R10");
    look(mkpc(7, 9, 4), 1, "R10");

    // R9: poison many entries, clear, all safe; clear with collision
    for (int i = 0; i < 64; i += 3) collide(mkpc(i % 16, i, 2), 32'h9000 + 32'(i) * 16, "R4");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
    for (int i = 0; i < 64; i++) look(mkpc(i % 16, i, 2), 1, "R9");
    cyc(1, mkpc(1, 11, 6), 1, 1, 32'h700, 1, 32'h700, mkpc(4, 12, 6), 0, 0, 1, "R9");
    look(mkpc(4, 12, 6), 1, "R9");
    look(mkpc(1, 11, 6), 1, "R9");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule